// File: doc/BRIEF.md
# Pin-Controlled Low-Power Hold Controller

This block sits between the pads of a small programmable-logic core and its logic array. It lets one dual-purpose pin take either of two roles. In one role the pin is an ordinary logic input. In the other it is a sleep request that freezes the whole device. A static configuration bit picks the role. In sleep-request mode, a high level on the pin passes through a two-stage synchronizer and then enters a hold state. In the hold state the block gates off every other input to the array and withdraws the clock enable from the core's registers. It also pins every pad output value and every output-enable at the level it had when the hold began.

Weak keepers on all input and bidirectional pads remember the last level that was actively driven onto each pin. The logic array therefore never sees a floating value, and no pull-up resistor is needed. The keepers stay in force throughout the hold. When the request drops, the hold ends after the same synchronizer delay. From then on the array sees live pins again and the pads follow the core.

Top module: `pd_hold_ctrl`

## Requirements
- R1: After synchronous reset, `hold` is 0, `core_ce` is 1, every keeper holds 0, and `pad_oe` follows `core_oe`.
- R2: With no hold, each `arr_in` bit equals the pin level when its `in_drv` bit is 1. When `in_drv` is 0, the bit equals the level the keeper captured on the previous clock edge.
- R3: With `cfg_pd_en` = 0, `arr_pd` equals `pd_pin`, and `hold` never rises however long `pd_pin` stays high.
- R4: With `cfg_pd_en` = 1, `arr_pd` is 0 whatever the level of `pd_pin`.
- R5: With `cfg_pd_en` = 1, take the first clock edge that samples `pd_pin` high as edge 1. `core_ce` falls after edge 2 and `hold` rises after edge 3.
- R6: While `hold` is 1, `arr_in` and `arr_io` keep the values they had at the entry edge, whatever the input pins do.
- R7: While `hold` is 1, `pad_out` and `pad_oe` keep the values `core_out` and `core_oe` had at the entry edge, whatever the core drives.
- R8: `core_ce` is 0 on every edge while `hold` is 1, so no core register can change during the hold.
- R9: Take the first edge that samples `pd_pin` low as edge 1. `hold` falls and `core_ce` rises after edge 3. From then on the outputs track live pins and core values again.
- R10: With no hold, each `arr_io` bit equals `core_out` when that bit's `core_oe` is 1. Otherwise it equals `io_ext_lvl` when `io_ext_drv` is 1, and otherwise the keeper's last level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pd_en | input | 1 | 1: dual-purpose pin is a sleep request; 0: it is a logic input |
| pd_pin | input | 1 | Raw dual-purpose pin |
| in_lvl | input | N_IN | Levels on the dedicated input pins |
| in_drv | input | N_IN | 1 where an input pin is actively driven from outside |
| io_ext_lvl | input | N_IO | External level on each bidirectional pad |
| io_ext_drv | input | N_IO | 1 where a bidirectional pad is driven from outside |
| core_out | input | N_IO | Output values produced by the core macrocells |
| core_oe | input | N_IO | Output-enables produced by the core |
| arr_in | output | N_IN | Dedicated-input values presented to the logic array |
| arr_pd | output | 1 | Dual-purpose pin as an array input (0 in sleep-request mode) |
| arr_io | output | N_IO | Pad feedback levels presented to the logic array |
| pad_out | output | N_IO | Output values sent to the pads |
| pad_oe | output | N_IO | Output-enables sent to the pads |
| core_ce | output | 1 | Clock enable for every core register |
| hold | output | 1 | 1 while the device is frozen |

## Verification
The bench builds the block with three dedicated inputs, two bidirectional pads and two synchronizer stages. With those sizes it can sweep every level and drive combination of the dedicated inputs, and all 256 combinations of value, enable, external level and external drive on the pads, against an arithmetic keeper model. The small sizes also keep entry and release short enough to count edge by edge. Inside the hold, twenty cycles of changing pins and core outputs confirm that nothing reaches the array or the pads.

// File: rtl/pd_hold_pkg.sv
package pd_hold_pkg;

    // One physical pin as seen from outside: level and whether anything drives it.
    typedef struct packed {
        logic lvl;
        logic drv;
    } pin_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } pd_state_e;

    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Keeper resolution: a driven pin wins, otherwise the remembered level.
    function automatic logic resolve_pin(pin_t p, logic last);
        return p.drv ? p.lvl : last;
    endfunction

    // Pad resolution: own driver first, then external driver, then keeper.
    function automatic logic resolve_pad(logic out, logic oe, pin_t ext, logic last);
        return oe ? out : resolve_pin(ext, last);
    endfunction

endpackage

// File: rtl/pd_hold_sync.sv
module pd_hold_sync
    import pd_hold_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_pd_en,
    input  logic pd_pin,
    output logic core_ce,
    output logic hold
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain_q;
    logic          req;
    pd_state_e     st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], pd_pin};
        end
    end

    assign req = cfg_pd_en & chain_q[LAST];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= req ? ST_HOLD : ST_RUN;
        end
    end

    assign hold    = (st_q == ST_HOLD);
    // Withdraw the enable one edge early so the entry edge leaves the core untouched.
    assign core_ce = !req && !hold;

endmodule

// File: rtl/pd_hold_keeper.sv
module pd_hold_keeper
    import pd_hold_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hold,
    input  pin_t [W-1:0]   pins,
    output logic [W-1:0]   seen
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic keep_q;
        logic live;

        assign live = resolve_pin(pins[g], keep_q);

        always_ff @(posedge clk) begin
            if (rst) begin
                keep_q <= 1'b0;
            end else if (!hold) begin
                keep_q <= live;
            end
        end

        assign seen[g] = hold ? keep_q : live;
    end

endmodule

// File: rtl/pd_hold_pad.sv
module pd_hold_pad
    import pd_hold_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hold,
    input  logic [W-1:0]   core_out,
    input  logic [W-1:0]   core_oe,
    input  pin_t [W-1:0]   ext,
    output logic [W-1:0]   pad_out,
    output logic [W-1:0]   pad_oe,
    output logic [W-1:0]   fb
);
    for (genvar g = 0; g < W; g++) begin : g_pad
        logic out_q;
        logic oe_q;
        logic lvl_q;
        logic live;

        assign live = resolve_pad(core_out[g], core_oe[g], ext[g], lvl_q);

        always_ff @(posedge clk) begin
            if (rst) begin
                out_q <= 1'b0;
                oe_q  <= 1'b0;
                lvl_q <= 1'b0;
            end else if (!hold) begin
                out_q <= core_out[g];
                oe_q  <= core_oe[g];
                lvl_q <= live;
            end
        end

        assign pad_out[g] = hold ? out_q : core_out[g];
        assign pad_oe[g]  = hold ? oe_q  : core_oe[g];
        assign fb[g]      = hold ? lvl_q : live;
    end

endmodule

// File: rtl/pd_hold_ctrl.sv
module pd_hold_ctrl
    import pd_hold_pkg::*;
#(
    parameter int unsigned N_IN        = 11,
    parameter int unsigned N_IO        = 10,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_pd_en,
    input  logic            pd_pin,
    input  logic [N_IN-1:0] in_lvl,
    input  logic [N_IN-1:0] in_drv,
    input  logic [N_IO-1:0] io_ext_lvl,
    input  logic [N_IO-1:0] io_ext_drv,
    input  logic [N_IO-1:0] core_out,
    input  logic [N_IO-1:0] core_oe,
    output logic [N_IN-1:0] arr_in,
    output logic            arr_pd,
    output logic [N_IO-1:0] arr_io,
    output logic [N_IO-1:0] pad_out,
    output logic [N_IO-1:0] pad_oe,
    output logic            core_ce,
    output logic            hold
);
    pin_t [N_IN-1:0] in_pins;
    pin_t [N_IO-1:0] io_pins;

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            in_pins[i].lvl = in_lvl[i];
            in_pins[i].drv = in_drv[i];
        end
        for (int i = 0; i < N_IO; i++) begin
            io_pins[i].lvl = io_ext_lvl[i];
            io_pins[i].drv = io_ext_drv[i];
        end
    end

    pd_hold_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .cfg_pd_en (cfg_pd_en),
        .pd_pin    (pd_pin),
        .core_ce   (core_ce),
        .hold      (hold)
    );

    pd_hold_keeper #(
        .W(N_IN)
    ) u_in_keep (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .pins (in_pins),
        .seen (arr_in)
    );

    pd_hold_pad #(
        .W(N_IO)
    ) u_pads (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold),
        .core_out (core_out),
        .core_oe  (core_oe),
        .ext      (io_pins),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .fb       (arr_io)
    );

    // In sleep-request mode the pin never reaches the array as data.
    assign arr_pd = cfg_pd_en ? 1'b0 : pd_pin;

endmodule

// File: rtl/pd_hold_chk.sv
module pd_hold_chk #(
    parameter int unsigned N_IN = 11,
    parameter int unsigned N_IO = 10
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_pd_en,
    input logic [N_IN-1:0] arr_in,
    input logic            arr_pd,
    input logic [N_IO-1:0] arr_io,
    input logic [N_IO-1:0] pad_out,
    input logic [N_IO-1:0] pad_oe,
    input logic            core_ce,
    input logic            hold
);
    // R8: frozen core never sees an enabled edge
    a_r8_no_ce_in_hold: assert property (@(posedge clk) disable iff (rst)
        hold |-> !core_ce);

    // R4: sleep-request mode masks the pin from the array
    a_r4_pd_masked: assert property (@(posedge clk) disable iff (rst)
        cfg_pd_en |-> (arr_pd == 1'b0));

    // R3: logic-input mode never enters the hold
    a_r3_no_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_pd_en |=> !hold);

    // R6: array inputs frozen across consecutive hold cycles
    a_r6_array_held: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold)) |-> ($stable(arr_in) && $stable(arr_io)));

    // R7: pad values and enables frozen across consecutive hold cycles
    a_r7_pads_held: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold)) |-> ($stable(pad_out) && $stable(pad_oe)));

    // R5: hold only begins after the enable was already withdrawn
    a_r5_ce_first: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> !$past(core_ce));

endmodule

bind pd_hold_ctrl pd_hold_chk #(
    .N_IN(N_IN),
    .N_IO(N_IO)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_pd_en (cfg_pd_en),
    .arr_in    (arr_in),
    .arr_pd    (arr_pd),
    .arr_io    (arr_io),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .core_ce   (core_ce),
    .hold      (hold)
);

// File: tb/pd_hold_ctrl_tb.sv
module pd_hold_ctrl_tb;
    localparam int unsigned NI = 3;
    localparam int unsigned NO = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_pd_en;
    logic          pd_pin;
    logic [NI-1:0] in_lvl, in_drv;
    logic [NO-1:0] io_ext_lvl, io_ext_drv, core_out, core_oe;
    logic [NI-1:0] arr_in;
    logic          arr_pd;
    logic [NO-1:0] arr_io, pad_out, pad_oe;
    logic          core_ce, hold;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pd_hold_ctrl #(
        .N_IN(NI),
        .N_IO(NO),
        .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst(rst), .cfg_pd_en(cfg_pd_en), .pd_pin(pd_pin),
        .in_lvl(in_lvl), .in_drv(in_drv),
        .io_ext_lvl(io_ext_lvl), .io_ext_drv(io_ext_drv),
        .core_out(core_out), .core_oe(core_oe),
        .arr_in(arr_in), .arr_pd(arr_pd), .arr_io(arr_io),
        .pad_out(pad_out), .pad_oe(pad_oe),
        .core_ce(core_ce), .hold(hold)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #4;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NI-1:0] k;
        logic [NO-1:0] ko;
        logic [NI-1:0] e_in;
        logic [NO-1:0] e_io;

        rst = 1'b1; cfg_pd_en = 1'b1; pd_pin = 1'b0;
        in_lvl = '0; in_drv = '0; io_ext_lvl = '0; io_ext_drv = '0;
        core_out = '0; core_oe = '0;
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;
        #1;
        // R1 reset state
        chk(hold === 1'b0,    "R1 hold", {7'd0, hold}, 8'd0);
        chk(core_ce === 1'b1, "R1 core_ce", {7'd0, core_ce}, 8'd1);
        chk(arr_in === '0,    "R1 keepers", {5'd0, arr_in}, 8'd0);
        chk(pad_oe === '0,    "R1 pad_oe", {6'd0, pad_oe}, 8'd0);

        // R2 exhaustive keeper sweep on dedicated inputs
        k = '0;
        for (int i = 0; i < 64; i++) begin
            in_lvl = i[2:0];
            in_drv = i[5:3];
            #1;
            e_in = (in_lvl & in_drv) | (k & ~in_drv);
            chk(arr_in === e_in, "R2 input keeper", {5'd0, arr_in}, {5'd0, e_in});
            k = e_in;
            next_cycle();
        end

        // R10 exhaustive pad feedback sweep
        in_drv = '1;
        ko = '0;
        for (int i = 0; i < 256; i++) begin
            core_out   = i[1:0];
            core_oe    = i[3:2];
            io_ext_lvl = i[5:4];
            io_ext_drv = i[7:6];
            #1;
            e_io = (core_oe & core_out) | (~core_oe & io_ext_drv & io_ext_lvl)
                 | (~core_oe & ~io_ext_drv & ko);
            chk(arr_io === e_io, "R10 pad feedback", {6'd0, arr_io}, {6'd0, e_io});
            chk({pad_oe, pad_out} === {core_oe, core_out}, "R10 pad pass",
                {4'd0, pad_oe, pad_out}, {4'd0, core_oe, core_out});
            ko = e_io;
            next_cycle();
        end

        // R3 logic-input mode
        cfg_pd_en = 1'b0;
        pd_pin = 1'b1;
        for (int i = 0; i < 6; i++) begin
            #1;
            chk(hold === 1'b0,   "R3 no hold", {7'd0, hold}, 8'd0);
            chk(core_ce === 1'b1, "R3 ce kept", {7'd0, core_ce}, 8'd1);
            chk(arr_pd === 1'b1, "R3 pin as data", {7'd0, arr_pd}, 8'd1);
            next_cycle();
        end
        pd_pin = 1'b0;
        #1;
        chk(arr_pd === 1'b0, "R3 pin as data low", {7'd0, arr_pd}, 8'd0);
        repeat (3) next_cycle();
        cfg_pd_en = 1'b1;
        #1;

        // R5 entry
        in_lvl = 3'b101; in_drv = 3'b111;
        io_ext_lvl = '0; io_ext_drv = '0;
        core_out = 2'b10; core_oe = 2'b11;
        pd_pin = 1'b1;
        #1;
        chk(arr_pd === 1'b0, "R4 pin masked", {7'd0, arr_pd}, 8'd0);
        next_cycle();
        chk(core_ce === 1'b1 && hold === 1'b0, "R5 after edge 1", {6'd0, core_ce, hold}, 8'h2);
        next_cycle();
        chk(core_ce === 1'b0 && hold === 1'b0, "R5 after edge 2", {6'd0, core_ce, hold}, 8'h0);
        next_cycle();
        chk(core_ce === 1'b0 && hold === 1'b1, "R5 after edge 3", {6'd0, core_ce, hold}, 8'h1);

        // R6 R7 R8 inside the hold
        for (int j = 0; j < 20; j++) begin
            in_lvl = j[2:0];
            in_drv = ~j[2:0];
            io_ext_lvl = j[1:0];
            io_ext_drv = j[3:2];
            core_out = j[1:0] + 2'd1;
            core_oe  = j[2:1];
            #1;
            chk(arr_in === 3'b101, "R6 inputs held", {5'd0, arr_in}, 8'h5);
            chk(arr_io === 2'b10,  "R6 feedback held", {6'd0, arr_io}, 8'h2);
            chk({pad_oe, pad_out} === 4'b1110, "R7 pads held", {4'd0, pad_oe, pad_out}, 8'hE);
            chk(core_ce === 1'b0,  "R8 ce off", {7'd0, core_ce}, 8'd0);
            chk(arr_pd === 1'b0,   "R4 pin masked in hold", {7'd0, arr_pd}, 8'd0);
            next_cycle();
        end

        // R9 release
        pd_pin = 1'b0;
        in_lvl = 3'b010; in_drv = 3'b111;
        core_out = 2'b01; core_oe = 2'b01;
        io_ext_lvl = 2'b10; io_ext_drv = 2'b10;
        #1;
        chk(arr_in === 3'b101, "R9 still held", {5'd0, arr_in}, 8'h5);
        next_cycle();
        chk(hold === 1'b1 && core_ce === 1'b0, "R9 after edge 1", {6'd0, core_ce, hold}, 8'h1);
        next_cycle();
        chk(hold === 1'b1 && core_ce === 1'b0, "R9 after edge 2", {6'd0, core_ce, hold}, 8'h1);
        next_cycle();
        chk(hold === 1'b0 && core_ce === 1'b1, "R9 after edge 3", {6'd0, core_ce, hold}, 8'h2);
        chk(arr_in === 3'b010, "R9 live inputs", {5'd0, arr_in}, 8'h2);
        chk({pad_oe, pad_out} === 4'b0101, "R9 live pads", {4'd0, pad_oe, pad_out}, 8'h5);
        chk(arr_io === 2'b11, "R9 live feedback", {6'd0, arr_io}, 8'h3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule